// File: doc/BRIEF.md
# PLL Calibration Sequencing Controller

This controller decides when a clock-synthesis loop has to run its internal calibration, and it tracks the loop's condition around that calibration. A calibration request can come from several events: a power-on reset, the release of the external reset, a change on the configuration pins, a register out-of-range report, or a drift of the measured input frequency. The request does not launch a calibration at once. The controller first waits until the input clock is usable, which means it is free of alarm, it is the selected clock, and, when the build requires it, the external reference is present.

Once a calibration has succeeded, the controller keeps the outcome. If the input clock is lost later, the loop goes into holdover. When the input clock comes back, the loop relocks without a new calibration. A trigger that arrives while a calibration is running is not lost: the calibration is repeated as soon as the current one reports done.

The analog loop, the calibration engine and the frequency measurement are outside this block. They reach it only through `cal_done`, `ppm_dev` and the clock-status inputs. All four outputs are registers.

Top module: `cal_seq`

## Requirements
- R1: While `por_n` is low, the outputs read `lol`=1, `cal_start`=0, `locked`=0 and `holdover`=0. After `por_n` rises, with `rst_ext_n` high, a calibration is requested as soon as the start condition of R5 holds.
- R2: While `rst_ext_n` is low, the controller is held in reset: `lol`=1, with no calibration start and no lock. The rising edge of `rst_ext_n` triggers a new calibration.
- R3: When any bit of `cfg_pins` differs from the value captured at the last calibration start, a recalibration is triggered. This applies from the locked state and from holdover.
- R4: `reg_oor`=1 triggers a recalibration.
- R5: `cal_start` is raised only in the cycle after a clock edge at which all of the following held: `clk_alarm`=0, `clk_active`=1, and `ref_present`=1 when `NEED_REF`=1. Until then the controller waits with `lol`=1.
- R6: `cal_start` is a one-cycle pulse. `lol` stays at 1 from that pulse until the calibration is done.
- R7: `cal_done`=1 during a calibration that has no pending trigger makes `locked`=1 in the next cycle. The current `ppm_dev` is then latched as the drift reference.
- R8: A trigger seen during a calibration is remembered. After `cal_done`, a new calibration is started instead of locking.
- R9: While locked, loss of the input (`clk_alarm`=1 or `clk_active`=0) gives `holdover`=1, `locked`=0 and `lol`=0 in the next cycle.
- R10: In holdover, the return of the input gives `locked`=1 in the next cycle, with no `cal_start`.
- R11: While locked, |`ppm_dev` − reference| ≥ `PPM_LIMIT` (default 500) triggers a recalibration. A smaller drift has no effect. Drift is ignored in holdover.
- R12: In every cycle, exactly one of `lol`, `locked` and `holdover` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_ext_n | input | 1 | External reset, active low, sampled on the clock |
| cfg_pins | input | CFG_W | Configuration pins: frequency, table, bandwidth and rate selects |
| reg_oor | input | 1 | Loop register out-of-range flag |
| clk_alarm | input | 1 | Input clock alarm |
| clk_active | input | 1 | Input clock is the selected active clock |
| ref_present | input | 1 | External reference present |
| cal_done | input | 1 | Calibration engine finished |
| ppm_dev | input | PPM_W | Signed measured input-frequency deviation in ppm |
| cal_start | output | 1 | One-cycle calibration start request |
| lol | output | 1 | Loss-of-lock alarm |
| holdover | output | 1 | Holdover mode |
| locked | output | 1 | Loop locked |

## Verification
The assertions watch several properties in every cycle:
- the three status outputs are mutually exclusive;
- `cal_start` is a single pulse that comes only after the clock has been valid, and `lol` is high while it is;
- lock is reached only from a completed calibration or from holdover;
- holdover is entered only from lock;
- the external reset holds the controller quiet.

Some behaviour can only be shown by the bench's scenarios, because it depends on the history of several events. This covers whether a trigger that comes during a calibration really forces a second calibration, whether a drift just under the threshold is ignored while one at the threshold is not, and whether a configuration change is measured against the value captured at the last start.

// File: rtl/cal_seq.sv
module cal_seq #(
  parameter int CFG_W     = 8,
  parameter int PPM_W     = 16,
  parameter int PPM_LIMIT = 500,
  parameter bit NEED_REF  = 1'b1
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    rst_ext_n,
  input  logic [CFG_W-1:0]        cfg_pins,
  input  logic                    reg_oor,
  input  logic                    clk_alarm,
  input  logic                    clk_active,
  input  logic                    ref_present,
  input  logic                    cal_done,
  input  logic signed [PPM_W-1:0] ppm_dev,
  output logic                    cal_start,
  output logic                    lol,
  output logic                    holdover,
  output logic                    locked
);

  localparam int DW = PPM_W + 1;
  localparam logic [DW-1:0] LIMIT = DW'(PPM_LIMIT);

  typedef enum logic [2:0] {S_RESET, S_WAIT, S_CAL, S_LOCK, S_HOLD} st_t;

  st_t                    st, nst;
  logic                   pend, nxt_pend;
  logic [CFG_W-1:0]       cfg_q;
  logic signed [PPM_W-1:0] ppm_ref;
  logic signed [DW-1:0]   drift;
  logic [DW-1:0]          drift_mag;
  logic                   in_ok, start_ok, hard_trig, ppm_trip;

  assign in_ok     = !clk_alarm && clk_active;
  assign start_ok  = in_ok && (ref_present || !NEED_REF);
  assign hard_trig = (cfg_pins != cfg_q) || reg_oor;
  assign drift     = DW'(ppm_dev) - DW'(ppm_ref);
  assign drift_mag = drift[DW-1] ? DW'(-drift) : DW'(drift);
  assign ppm_trip  = drift_mag >= LIMIT;

  always_comb begin
    nst      = st;
    nxt_pend = pend;
    if (!rst_ext_n) begin
      nst      = S_RESET;
      nxt_pend = 1'b0;
    end else begin
      case (st)
        S_RESET: nst = S_WAIT;
        S_WAIT: begin
          nxt_pend = 1'b0;
          if (start_ok) nst = S_CAL;
        end
        S_CAL: begin
          if (hard_trig) nxt_pend = 1'b1;
          if (cal_done) begin
            nst      = (pend || hard_trig) ? S_WAIT : S_LOCK;
            nxt_pend = 1'b0;
          end
        end
        S_LOCK: begin
          if (hard_trig || ppm_trip) nst = S_WAIT;
          else if (!in_ok)           nst = S_HOLD;
        end
        S_HOLD: begin
          if (hard_trig)  nst = S_WAIT;
          else if (in_ok) nst = S_LOCK;
        end
        default: nst = S_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_RESET;
      pend      <= 1'b0;
      cfg_q     <= '0;
      ppm_ref   <= '0;
      cal_start <= 1'b0;
      lol       <= 1'b1;
      holdover  <= 1'b0;
      locked    <= 1'b0;
    end else begin
      st        <= nst;
      pend      <= nxt_pend;
      if (st == S_WAIT && nst == S_CAL) cfg_q <= cfg_pins;
      if (st == S_CAL && nst == S_LOCK) ppm_ref <= ppm_dev;
      cal_start <= (st == S_WAIT) && (nst == S_CAL);
      lol       <= (nst == S_RESET) || (nst == S_WAIT) || (nst == S_CAL);
      holdover  <= nst == S_HOLD;
      locked    <= nst == S_LOCK;
    end
  end

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
  parameter bit NEED_REF = 1'b1
) (
  input logic clk,
  input logic por_n,
  input logic rst_ext_n,
  input logic clk_alarm,
  input logic clk_active,
  input logic ref_present,
  input logic cal_done,
  input logic cal_start,
  input logic lol,
  input logic holdover,
  input logic locked
);

  p_one_status_r12: assert property (@(posedge clk) disable iff (!por_n)
    $countones({lol, locked, holdover}) == 1);

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    cal_start |=> !cal_start);

  p_start_lol_r6: assert property (@(posedge clk) disable iff (!por_n)
    cal_start |-> lol);

  p_start_gated_r5: assert property (@(posedge clk) disable iff (!por_n)
    cal_start |-> $past(!clk_alarm && clk_active && (ref_present || !NEED_REF)));

  p_lock_source_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(locked) |-> ($past(cal_done) || $past(holdover)));

  p_hold_entry_r9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(holdover) |-> $past(locked));

  p_ext_reset_r2: assert property (@(posedge clk) disable iff (!por_n)
    !rst_ext_n |=> (lol && !cal_start && !locked));

endmodule

bind cal_seq cal_seq_chk #(.NEED_REF(NEED_REF)) u_chk (
  .clk(clk), .por_n(por_n), .rst_ext_n(rst_ext_n), .clk_alarm(clk_alarm),
  .clk_active(clk_active), .ref_present(ref_present), .cal_done(cal_done),
  .cal_start(cal_start), .lol(lol), .holdover(holdover), .locked(locked)
);

// File: tb/cal_seq_bench.sv
module cal_seq_bench;
  logic clk = 1'b0;
  logic por_n, rst_ext_n, reg_oor, clk_alarm, clk_active, ref_present, cal_done;
  logic [7:0] cfg_pins;
  logic signed [15:0] ppm_dev;
  logic cal_start, lol, holdover, locked;

  int errors = 0, checks = 0;
  string req = "R1";

  int ms = 0, mref = 0;
  bit mpend = 0, m_start = 0;
  logic [7:0] mcfg = '0;

  always #4 clk = ~clk;

  cal_seq u_cal_seq (
    .clk(clk), .por_n(por_n), .rst_ext_n(rst_ext_n), .cfg_pins(cfg_pins),
    .reg_oor(reg_oor), .clk_alarm(clk_alarm), .clk_active(clk_active),
    .ref_present(ref_present), .cal_done(cal_done), .ppm_dev(ppm_dev),
    .cal_start(cal_start), .lol(lol), .holdover(holdover), .locked(locked)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    int nms, d;
    bit hard, st;
    hard = (cfg_pins != mcfg) || reg_oor;
    d = int'(ppm_dev) - mref;
    if (d < 0) d = -d;
    nms = ms;
    st = 0;
    if (!por_n) begin
      nms = 0; mpend = 0; mcfg = '0; mref = 0;
    end else if (!rst_ext_n) begin
      nms = 0; mpend = 0;
    end else if (ms == 0) nms = 1;
    else if (ms == 1) begin
      mpend = 0;
      if (!clk_alarm && clk_active && ref_present) begin
        nms = 2; st = 1; mcfg = cfg_pins;
      end
    end else if (ms == 2) begin
      if (hard) mpend = 1;
      if (cal_done) begin
        nms = mpend ? 1 : 3;
        if (nms == 3) mref = int'(ppm_dev);
        mpend = 0;
      end
    end else if (ms == 3) begin
      if (hard || d >= 500) nms = 1;
      else if (clk_alarm || !clk_active) nms = 4;
    end else if (ms == 4) begin
      if (hard) nms = 1;
      else if (!clk_alarm && clk_active) nms = 3;
    end
    ms = nms;
    m_start = st;
    @(posedge clk);
    @(negedge clk);
    check(req, "cal_start", cal_start, m_start);
    check(req, "lol", lol, ms <= 2);
    check(req, "locked", locked, ms == 3);
    check(req, "holdover", holdover, ms == 4);
    check("R12", "one status", 1'($countones({lol, locked, holdover}) == 1), 1'b1);
  endtask

  task automatic run_cal(int len);
    repeat (len) tick();
    cal_done = 1'b1; tick(); cal_done = 1'b0; tick();
  endtask

  initial begin
    por_n = 0; rst_ext_n = 1; cfg_pins = 8'h3C; reg_oor = 0;
    clk_alarm = 1; clk_active = 0; ref_present = 0; cal_done = 0; ppm_dev = 0;
    @(negedge clk);
    req = "R1";
    repeat (3) tick();
    por_n = 1;
    req = "R5";
    repeat (3) tick();
    clk_alarm = 0; clk_active = 1;
    repeat (3) tick();
    ref_present = 1;
    req = "R1";
    tick();
    req = "R6";
    ppm_dev = 16'sd100;
    repeat (3) tick();
    req = "R7";
    run_cal(0);
    tick();
    req = "R11";
    ppm_dev = 16'sd599; repeat (3) tick();
    ppm_dev = -16'sd399; repeat (2) tick();
    ppm_dev = -16'sd400; tick(); tick();
    run_cal(2);
    ppm_dev = 16'sd100; repeat (2) tick();
    req = "R3";
    cfg_pins = 8'h3D; repeat (3) tick();
    run_cal(1);
    req = "R4";
    reg_oor = 1; tick(); reg_oor = 0; repeat (2) tick();
    req = "R8";
    reg_oor = 1; tick(); reg_oor = 0; tick();
    run_cal(1);
    repeat (2) tick();
    run_cal(1);
    req = "R9";
    clk_alarm = 1; repeat (2) tick();
    req = "R11";
    ppm_dev = 16'sd2000; repeat (2) tick();
    req = "R10";
    clk_alarm = 0; repeat (3) tick();
    ppm_dev = 16'sd100; tick();
    req = "R9";
    clk_active = 0; repeat (2) tick();
    req = "R3";
    cfg_pins = 8'h80; repeat (3) tick();
    clk_active = 1; repeat (2) tick();
    run_cal(1);
    req = "R2";
    rst_ext_n = 0; repeat (3) tick();
    rst_ext_n = 1; repeat (3) tick();
    run_cal(2);
    req = "R5";
    ref_present = 0; reg_oor = 1; tick(); reg_oor = 0; repeat (3) tick();
    ref_present = 1; repeat (2) tick();
    run_cal(1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule